// File: doc/BRIEF.md
# Non-volatile memory row-buffer controller

This block fronts one bank of a non-volatile main memory whose row buffer is decoupled from the cell array. Activating a row copies every block of that row out of the array into a local buffer without disturbing the stored cells. From then on, reads and writes to that row are served from the buffer alone. The cells never leak, so the block issues no refresh and no precharge. Its work is to decide, at each row change, which buffered blocks must be written back before the next row is fetched.

A two-bit mode input selects the writeback policy.
- Mode 0 writes the whole buffer back on every row change.
- Mode 1 keeps one dirty flag for the buffer and skips the writeback when that flag is clear.
- Mode 2 keeps one dirty flag per block and writes back only the dirty blocks.
- Mode 3 sends every write straight to the array. The buffer therefore stays clean and is simply dropped on a row change.

Requests arrive one at a time on a valid/ready port. Each carries a row address, a block index and one block of data. Three counters report activations, blocks written back, and writes sent directly to the array.

Top module: `nvm_rowbuf_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, all counters are 0 and no row is open. The first access is a row miss that performs no writeback.
- R2: A read or buffered write to the open row responds `HIT_LAT` cycles after acceptance. A row miss responds `MISS_LAT` cycles after the end of any writeback, that is, `MISS_LAT + n*WR_PULSE` cycles after acceptance when n blocks are written back.
- R3: On a row miss, the controller issues one row-read request and loads all `NBLK` returned blocks into the buffer, in block order 0 upward. Every read returns the most recent data written to that row and block.
- R4: In mode 0 (full writeback), a row change with a row open writes all `NBLK` blocks of the old row to the array, whether or not they were modified.
- R5: In mode 1 (row-level dirty flag), a row change writes all blocks back if any write reached the buffer since activation, and writes nothing back otherwise.
- R6: In mode 2 (block-level dirty flags), a row change writes back exactly the blocks written since activation, in ascending block order. Clean blocks are never written.
- R7: In mode 3 (write bypass), a write goes directly to the array and responds after `WR_PULSE` cycles. It neither activates a row nor evicts the open row. A later row change writes nothing back.
- R8: In mode 3, a bypass write whose row is the open row also updates the buffered copy of that block.
- R9: `req_ready` stays 0 from the cycle after acceptance until the cycle in which `rsp_valid` is issued.
- R10: `cnt_act` counts activations, `cnt_wb` counts block writebacks and `cnt_byp` counts bypass writes. The sum of the last two equals the number of array block writes.
- R11: Each array block write holds `arr_wr_en`, the row and the block steady for exactly `WR_PULSE` cycles. `arr_wr_last` marks the final cycle, in which the array commits the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Writeback policy: 0 full, 1 row flag, 2 block flags, 3 bypass |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_blk | input | $clog2(NBLK) | Block index within the row |
| req_wdata | input | DATA_W | Write block data |
| rsp_valid | output | 1 | One-cycle response (read data or write acknowledge) |
| rsp_data | output | DATA_W | Read data, valid with `rsp_valid` for reads |
| arr_rd_req | output | 1 | One-cycle row-read request to the array |
| arr_rd_row | output | ROW_W | Row to read |
| arr_rd_valid | input | 1 | Array returns one block (blocks arrive in order 0 upward) |
| arr_rd_data | input | DATA_W | Returned block data |
| arr_wr_en | output | 1 | Block write pulse active |
| arr_wr_last | output | 1 | Last cycle of the pulse; the array commits the data here |
| arr_wr_row | output | ROW_W | Row of the block being written |
| arr_wr_blk | output | $clog2(NBLK) | Block being written |
| arr_wr_data | output | DATA_W | Block write data |
| cnt_act | output | CNT_W | Activation count |
| cnt_wb | output | CNT_W | Written-back block count |
| cnt_byp | output | CNT_W | Bypass write count |

## Verification
The assertions take it as given that the array returns all blocks of a row shortly after `arr_rd_req`, well within `MISS_LAT` cycles. They also assume that `mode` changes only while the controller is idle, that requests hold their fields stable while `req_valid` waits for ready, and that `WR_PULSE` is at least 2.

The bench's array model answers a row read two cycles after the request. The bench changes `mode` only between responses, and it holds every request steady from the cycle it is raised until it is accepted.

// File: rtl/nvm_rb_pkg.sv
package nvm_rb_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_SEL  = 2'd1,
    MODE_PART = 2'd2,
    MODE_BYP  = 2'd3
  } wb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_LAT  = 2'd2,
    ST_BYP  = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/rb_store.sv
module rb_store #(
  parameter int NBLK   = 32,
  parameter int DATA_W = 512
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NBLK)-1:0] waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [$clog2(NBLK)-1:0] raddr,
  output logic [DATA_W-1:0]       rdata
);
  logic [DATA_W-1:0] mem [NBLK];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rb_dirty.sv
module rb_dirty
  import nvm_rb_pkg::*;
#(
  parameter int NBLK = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    set,
  input  logic [$clog2(NBLK)-1:0] set_idx,
  input  logic                    open,
  input  wb_mode_e                mode,
  output logic [NBLK-1:0]         dirty,
  output logic [NBLK-1:0]         wb_mask
);
  for (genvar g = 0; g < NBLK; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr) dirty[g] <= 1'b0;
      else if (set && set_idx == g) dirty[g] <= 1'b1;
    end
  end

  always_comb begin
    wb_mask = '0;
    if (open) begin
      case (mode)
        MODE_FULL: wb_mask = '1;
        MODE_SEL:  wb_mask = (|dirty) ? '1 : '0;
        default:   wb_mask = dirty;
      endcase
    end
  end
endmodule

// File: rtl/nvm_rb_stats.sv
module nvm_rb_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_act,
  input  logic             inc_wb,
  input  logic             inc_byp,
  output logic [CNT_W-1:0] cnt_act,
  output logic [CNT_W-1:0] cnt_wb,
  output logic [CNT_W-1:0] cnt_byp
);
  localparam int NCNT = 3;
  logic [NCNT-1:0]  inc;
  logic [CNT_W-1:0] cnt [NCNT];

  assign inc = {inc_byp, inc_wb, inc_act};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign cnt_act = cnt[0];
  assign cnt_wb  = cnt[1];
  assign cnt_byp = cnt[2];
endmodule

// File: rtl/nvm_rowbuf_ctrl.sv
module nvm_rowbuf_ctrl
  import nvm_rb_pkg::*;
#(
  parameter int ROW_W    = 16,
  parameter int NBLK     = 32,
  parameter int DATA_W   = 512,
  parameter int HIT_LAT  = 75,
  parameter int MISS_LAT = 125,
  parameter int WR_PULSE = 25,
  parameter int CNT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [$clog2(NBLK)-1:0] req_blk,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    arr_rd_req,
  output logic [ROW_W-1:0]        arr_rd_row,
  input  logic                    arr_rd_valid,
  input  logic [DATA_W-1:0]       arr_rd_data,
  output logic                    arr_wr_en,
  output logic                    arr_wr_last,
  output logic [ROW_W-1:0]        arr_wr_row,
  output logic [$clog2(NBLK)-1:0] arr_wr_blk,
  output logic [DATA_W-1:0]       arr_wr_data,
  output logic [CNT_W-1:0]        cnt_act,
  output logic [CNT_W-1:0]        cnt_wb,
  output logic [CNT_W-1:0]        cnt_byp
);
  localparam int BLK_W = $clog2(NBLK);
  localparam int LAT_W = $clog2(MISS_LAT + 1);
  localparam int PC_W  = $clog2(WR_PULSE + 1);

  wb_mode_e   md;
  ctl_state_e state;
  assign md = wb_mode_e'(mode);

  logic              row_open, fill_done;
  logic [ROW_W-1:0]  row_q, op_row;
  logic [BLK_W-1:0]  op_blk, fill_idx, wb_cur;
  logic              op_wr;
  logic [DATA_W-1:0] op_data, st_rdata, st_wdata;
  logic [LAT_W-1:0]  base_q, lat_cnt;
  logic [PC_W-1:0]   pc;
  logic [NBLK-1:0]   wb_left, wb_rest, wb_mask, dirty;

  logic accept, hit, byp_acc, hit_acc, miss_acc, pulse_end, wb_last;
  logic open_now, lat_done, byp_done, req_buf_wr, st_we;
  logic [ROW_W-1:0] open_row_n;
  logic [BLK_W-1:0] st_waddr, st_raddr;

  function automatic logic [BLK_W-1:0] first_set(input logic [NBLK-1:0] m);
    first_set = '0;
    for (int i = NBLK - 1; i >= 0; i--)
      if (m[i]) first_set = BLK_W'(i);
  endfunction

  always_comb begin
    hit        = row_open && (row_q == req_row);
    accept     = (state == ST_IDLE) && req_valid;
    byp_acc    = accept && (md == MODE_BYP) && req_write;
    hit_acc    = accept && !byp_acc && hit;
    miss_acc   = accept && !byp_acc && !hit;
    pulse_end  = (pc == PC_W'(WR_PULSE - 1));
    wb_cur     = first_set(wb_left);
    wb_rest    = wb_left & ~(NBLK'(1) << wb_cur);
    wb_last    = (state == ST_WB) && pulse_end && (wb_rest == '0);
    open_now   = (miss_acc && (wb_mask == '0)) || wb_last;
    open_row_n = (state == ST_IDLE) ? req_row : op_row;
    lat_done   = (state == ST_LAT) && fill_done && (lat_cnt >= base_q - LAT_W'(1));
    byp_done   = (state == ST_BYP) && pulse_end;
    req_buf_wr = (lat_done && op_wr) || (byp_done && row_open && (row_q == op_row));
    st_we      = arr_rd_valid || req_buf_wr;
    st_waddr   = arr_rd_valid ? fill_idx : op_blk;
    st_wdata   = arr_rd_valid ? arr_rd_data : op_data;
    st_raddr   = (state == ST_WB) ? wb_cur : op_blk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      row_open   <= 1'b0;
      row_q      <= '0;
      fill_done  <= 1'b0;
      fill_idx   <= '0;
      rsp_valid  <= 1'b0;
      arr_rd_req <= 1'b0;
      arr_rd_row <= '0;
      op_row     <= '0;
      op_blk     <= '0;
      op_wr      <= 1'b0;
      op_data    <= '0;
      base_q     <= '0;
      lat_cnt    <= '0;
      pc         <= '0;
      wb_left    <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      arr_rd_req <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          op_row  <= req_row;
          op_blk  <= req_blk;
          op_wr   <= req_write;
          op_data <= req_wdata;
          pc      <= '0;
          lat_cnt <= '0;
          base_q  <= hit_acc ? LAT_W'(HIT_LAT) : LAT_W'(MISS_LAT);
          if (byp_acc) state <= ST_BYP;
          else if (hit_acc || wb_mask == '0) state <= ST_LAT;
          else begin
            state   <= ST_WB;
            wb_left <= wb_mask;
          end
        end
        ST_WB: begin
          if (pulse_end) begin
            pc      <= '0;
            wb_left <= wb_rest;
            if (wb_rest == '0) state <= ST_LAT;
          end else pc <= pc + 1'b1;
        end
        ST_LAT: begin
          if (lat_cnt < base_q) lat_cnt <= lat_cnt + 1'b1;
          if (lat_done) begin
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: begin
          if (byp_done) begin
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end else pc <= pc + 1'b1;
        end
      endcase
      if (open_now) begin
        arr_rd_req <= 1'b1;
        arr_rd_row <= open_row_n;
        row_q      <= open_row_n;
        row_open   <= 1'b1;
        fill_done  <= 1'b0;
        fill_idx   <= '0;
      end else if (arr_rd_valid) begin
        fill_idx <= fill_idx + 1'b1;
        if (fill_idx == BLK_W'(NBLK - 1)) fill_done <= 1'b1;
      end
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign rsp_data    = st_rdata;
  assign arr_wr_en   = (state == ST_WB) || (state == ST_BYP);
  assign arr_wr_last = arr_wr_en && pulse_end;
  assign arr_wr_row  = (state == ST_WB) ? row_q : op_row;
  assign arr_wr_blk  = (state == ST_WB) ? wb_cur : op_blk;
  assign arr_wr_data = (state == ST_WB) ? st_rdata : op_data;

  rb_store #(.NBLK(NBLK), .DATA_W(DATA_W)) i_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .raddr(st_raddr), .rdata(st_rdata)
  );

  rb_dirty #(.NBLK(NBLK)) i_dirty (
    .clk(clk), .rst(rst), .clr(open_now), .set(lat_done && op_wr),
    .set_idx(op_blk), .open(row_open), .mode(md),
    .dirty(dirty), .wb_mask(wb_mask)
  );

  nvm_rb_stats #(.CNT_W(CNT_W)) i_stats (
    .clk(clk), .rst(rst), .inc_act(open_now),
    .inc_wb((state == ST_WB) && pulse_end), .inc_byp(byp_done),
    .cnt_act(cnt_act), .cnt_wb(cnt_wb), .cnt_byp(cnt_byp)
  );

  // R9: no second request while one is in flight
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R11: a write pulse keeps its target steady until its last cycle
  p_pulse_steady_r11: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_en && !arr_wr_last) |=> (arr_wr_en && $stable(arr_wr_row) && $stable(arr_wr_blk)));

  // R3: a freshly activated row starts with no dirty blocks
  p_open_clean_r3: assert property (@(posedge clk) disable iff (rst)
    arr_rd_req |-> (dirty == '0));

  // R2: each response lasts a single cycle
  p_rsp_single_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7: a bypass write never activates a row
  p_byp_no_open_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BYP) |-> !arr_rd_req);

  // R5: a clean row under the row-level flag goes straight to activation
  p_sel_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (miss_acc && md == MODE_SEL && dirty == '0) |=> (state == ST_LAT));
endmodule

// File: tb/test_nvm_rowbuf_ctrl.sv
module test_nvm_rowbuf_ctrl;
  localparam int ROW_W = 4;
  localparam int ROWS  = 16;
  localparam int NB    = 4;
  localparam int BW    = 2;
  localparam int DW    = 512;
  localparam int HIT   = 75;
  localparam int MISS  = 125;
  localparam int PULSE = 25;
  localparam int CW    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd2;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [BW-1:0] req_blk = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, arr_rd_req, arr_wr_en, arr_wr_last;
  logic [DW-1:0] rsp_data, arr_wr_data;
  logic [ROW_W-1:0] arr_rd_row, arr_wr_row;
  logic [BW-1:0] arr_wr_blk;
  logic arr_rd_valid = 1'b0;
  logic [DW-1:0] arr_rd_data = '0;
  logic [CW-1:0] cnt_act, cnt_wb, cnt_byp;

  always #10 clk = ~clk;

  nvm_rowbuf_ctrl #(.ROW_W(ROW_W), .NBLK(NB), .DATA_W(DW), .HIT_LAT(HIT),
    .MISS_LAT(MISS), .WR_PULSE(PULSE), .CNT_W(CW)) i_nvm_rowbuf_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_blk(req_blk), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .arr_rd_req(arr_rd_req),
    .arr_rd_row(arr_rd_row), .arr_rd_valid(arr_rd_valid), .arr_rd_data(arr_rd_data),
    .arr_wr_en(arr_wr_en), .arr_wr_last(arr_wr_last), .arr_wr_row(arr_wr_row),
    .arr_wr_blk(arr_wr_blk), .arr_wr_data(arr_wr_data),
    .cnt_act(cnt_act), .cnt_wb(cnt_wb), .cnt_byp(cnt_byp));

  int checks = 0, errors = 0, cyc = 0;
  int acc_cyc = 0, wr_commits = 0, pulse_bad = 0, pulse_run = 0;
  bit busy = 0, ready_viol = 0, finished = 0;

  typedef struct {
    bit    wr;
    logic [DW-1:0] data;
    int    lat;
    string tag;
  } exp_t;
  exp_t sb[$];

  logic [DW-1:0] amem [ROWS][NB];
  logic [DW-1:0] gold [ROWS][NB];
  bit m_open = 0;
  int m_row = 0;
  bit [NB-1:0] m_dirty = '0;
  int e_act = 0, e_wb = 0, e_byp = 0;

  function automatic logic [DW-1:0] pat(int r, int b, int salt);
    return {16{r[7:0], b[7:0], salt[15:0]}};
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // array model: row reads answer two cycles after the request
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && arr_rd_req) begin
        automatic int r = int'(arr_rd_row);
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
          arr_rd_valid = 1'b1;
          arr_rd_data  = amem[r][b];
          @(negedge clk);
        end
        arr_rd_valid = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && arr_wr_en) pulse_run++;
      if (!rst && arr_wr_last) begin
        if (pulse_run != PULSE) pulse_bad++;
        pulse_run = 0;
        amem[int'(arr_wr_row)][int'(arr_wr_blk)] = arr_wr_data;
        wr_commits++;
      end
    end
  end

  // monitor: pops expected items as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (busy && !rsp_valid && req_ready) ready_viol = 1;
      if (rsp_valid) begin
        if (sb.size() == 0) check(0, "R2 unexpected response", 1, 0);
        else begin
          automatic exp_t e = sb.pop_front();
          check(cyc - acc_cyc == e.lat, {e.tag, " latency"}, cyc - acc_cyc, e.lat);
          if (!e.wr)
            check(rsp_data == e.data, {e.tag, " R3 data"}, rsp_data[31:0], e.data[31:0]);
          check(!ready_viol, {e.tag, " R9 ready low while busy"}, ready_viol, 0);
        end
        busy = 0;
      end
    end
  end

  // driver: computes the expected result and pushes it before issuing
  task automatic do_req(bit wr, int r, int b, int salt, string tag);
    exp_t e;
    e.wr = wr;
    e.tag = tag;
    if (wr) gold[r][b] = pat(r, b, salt);
    if (mode == 2'd3 && wr) begin
      e.lat = PULSE;
      e_byp++;
    end else if (m_open && m_row == r) begin
      e.lat = HIT;
      if (wr) m_dirty[b] = 1'b1;
    end else begin
      automatic int n = 0;
      if (m_open) begin
        if (mode == 2'd0) n = NB;
        else if (mode == 2'd1) n = (m_dirty != 0) ? NB : 0;
        else n = $countones(m_dirty);
      end
      e.lat = MISS + n * PULSE;
      e_wb += n;
      e_act++;
      m_open = 1;
      m_row = r;
      m_dirty = '0;
      if (wr) m_dirty[b] = 1'b1;
    end
    e.data = gold[r][b];
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_row   = ROW_W'(r);
    req_blk   = BW'(b);
    req_wdata = pat(r, b, salt);
    while (!req_ready) @(negedge clk);
    sb.push_back(e);
    acc_cyc = cyc + 1;
    @(posedge clk);
    busy = 1;
    ready_viol = 0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (busy || sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R9 actual=busy expected=idle");
    finish_run();
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < NB; b++) begin
        amem[r][b] = pat(r, b, 16'h5a00);
        gold[r][b] = pat(r, b, 16'h5a00);
      end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    check(cnt_act == 0, "R1 act counter reset", cnt_act, 0);
    check(cnt_wb == 0, "R1 wb counter reset", cnt_wb, 0);
    check(cnt_byp == 0, "R1 byp counter reset", cnt_byp, 0);
    check(arr_wr_en == 1'b0, "R1 no array write after reset", arr_wr_en, 0);

    // block-level dirty flags (mode 2)
    mode = 2'd2;
    do_req(0, 1, 0, 0, "R1 first access miss");
    do_req(0, 1, 2, 0, "R2 read hit");
    do_req(1, 1, 1, 11, "R2 write hit");
    do_req(1, 1, 3, 12, "R6 write hit");
    do_req(0, 1, 1, 0, "R3 read back buffered");
    do_req(0, 2, 0, 0, "R6 switch two dirty");
    do_req(0, 1, 3, 0, "R6 clean switch and writeback data");
    drain();
    check(cnt_wb == 2, "R6 only dirty blocks written", cnt_wb, 2);
    check(wr_commits == 2, "R6 array writes", wr_commits, 2);

    // row-level flag (mode 1)
    mode = 2'd1;
    do_req(0, 3, 0, 0, "R5 clean row skipped");
    do_req(1, 3, 2, 21, "R5 write dirties row");
    do_req(0, 4, 1, 0, "R5 dirty row written whole");
    do_req(0, 3, 2, 0, "R5 data after writeback");
    drain();
    check(cnt_wb == 6, "R5 wb count", cnt_wb, 6);

    // full writeback (mode 0)
    mode = 2'd0;
    do_req(0, 5, 0, 0, "R4 clean row still written");
    do_req(1, 5, 3, 31, "R4 write");
    do_req(0, 6, 2, 0, "R4 switch writes all");
    do_req(0, 5, 3, 0, "R4 data");
    drain();
    check(cnt_wb == 18, "R4 wb count", cnt_wb, 18);

    // bypass (mode 3)
    mode = 2'd3;
    do_req(0, 7, 0, 0, "R7 read miss no writeback");
    do_req(1, 7, 1, 41, "R8 bypass write to open row");
    do_req(0, 7, 1, 0, "R8 hit sees bypass data");
    do_req(1, 9, 2, 42, "R7 bypass write to closed row");
    do_req(0, 7, 3, 0, "R7 open row kept");
    do_req(0, 9, 2, 0, "R7 switch discards buffer");
    do_req(0, 7, 1, 0, "R7 array holds bypass data");
    drain();

    check(cnt_act == CW'(e_act), "R10 activation count", cnt_act, e_act);
    check(cnt_wb == CW'(e_wb), "R10 writeback count", cnt_wb, e_wb);
    check(cnt_byp == CW'(e_byp), "R10 bypass count", cnt_byp, e_byp);
    check(wr_commits == e_wb + e_byp, "R10 array writes match counters", wr_commits, e_wb + e_byp);
    check(pulse_bad == 0, "R11 write pulse length", pulse_bad, 0);
    finish_run();
  end
endmodule